// File: doc/BRIEF.md
# I2C Bus Recovery Sequencer

This block puts a downstream I2C bus into a known state before a newly chosen upstream master is connected to it. Slaves that were left in the middle of a transfer may be holding SDA low. To free them, the sequencer toggles SCL nine times with SDA released. It then gives one more clock with SDA released, which the slaves read as a not-acknowledge. Last, it creates a STOP condition. Only after the STOP does it tell the selector to connect the channel, and it raises a completion interrupt toward the upstream channel that asked for the switch. If recovery is disabled, the connect request comes out at once and no interrupt is raised.

The block drives the bus lines only through pull-low enables (`scl_pull_o`, `sda_pull_o`). A 1 pulls the line low and a 0 releases it to the external pull-up. Each SCL low and high phase lasts `PHASE_CYC` system clocks. The default of 500 gives 5 µs per phase at 100 MHz, which is a 100 kHz bus clock and stays under the 400 kHz ceiling. Clock stretching and arbitration are not handled.

The controller is a Moore state machine with these states:
- `ST_IDLE`: waiting for a start pulse.
- `ST_BYPASS`: immediate connect, used when recovery is disabled.
- `ST_CLK_LO` and `ST_CLK_HI`: the nine recovery clocks.
- `ST_NACK_LO` and `ST_NACK_HI`: the not-acknowledge clock.
- `ST_STOP_LO`: SCL low. SDA is pulled from the second cycle of this phase.
- `ST_STOP_HI`: SCL released, SDA still pulled.
- `ST_FINISH`: SDA released, giving the STOP, and connect and interrupt issued.

The transitions are:
- `ST_IDLE` goes to `ST_CLK_LO` on start with recovery enabled, or to `ST_BYPASS` on start with recovery disabled.
- `ST_CLK_LO` goes to `ST_CLK_HI` at the end of its phase.
- `ST_CLK_HI` goes back to `ST_CLK_LO` at the end of its phase, or to `ST_NACK_LO` after the ninth pulse.
- `ST_NACK_LO`, `ST_NACK_HI`, `ST_STOP_LO` and `ST_STOP_HI` each advance to the next state when their phase ends.
- `ST_STOP_HI` goes to `ST_FINISH`.
- `ST_FINISH` and `ST_BYPASS` return to `ST_IDLE` after one cycle.

All outputs are registered from the state, so they lag the state by one clock.

Top module: `i2c_recovery_seq`

## Requirements
- R1: A start pulse sampled with `recov_en_i`=1 produces exactly nine SCL low pulses with SDA released, followed by the NACK and STOP phases.
- R2: After the nine clocks, a tenth SCL low/high pulse (the NACK) occurs with SDA still released. SDA is first pulled during the eleventh SCL low phase.
- R3: The STOP works as follows:
  - SDA is pulled only while SCL has been pulled for at least one earlier cycle, so no START condition is ever formed.
  - SDA is released while SCL is released, in the same cycle that `connect_o` is high.
- R4: Every SCL low and high phase inside a sequence lasts exactly `PHASE_CYC` clocks.
- R5: If start is sampled at edge E, `connect_o` is high for exactly one cycle, the cycle following edge E+22·`PHASE_CYC`+1.
- R6: On a recovery connect, `irq_o` has exactly one bit set, bit index equal to the `req_ch_i` value latched at start. `conn_ch_o` carries that same value.
- R7: If start is sampled at edge E with `recov_en_i`=0:
  - `connect_o` is high in the cycle following edge E+1.
  - `irq_o` stays 0.
  - SCL and SDA are never pulled.
- R8: A start pulse that arrives while a sequence is running is ignored, together with its `req_ch_i`.
- R9: Reset aborts a running sequence. Both lines are released and `busy_o` is low at once. No connect follows after reset is removed.
- R10: The lines are only pulled or released:
  - While `busy_o` is low, neither line is pulled and `connect_o` is low.
  - `busy_o` is high during a running sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle request to switch channel |
| recov_en_i | input | 1 | 1: run recovery before connect; 0: connect at once |
| req_ch_i | input | CHW | Upstream channel that requests the bus |
| scl_pull_o | output | 1 | 1 pulls downstream SCL low |
| sda_pull_o | output | 1 | 1 pulls downstream SDA low |
| busy_o | output | 1 | Sequence or bypass in progress |
| connect_o | output | 1 | One-cycle pulse: connect channel now |
| conn_ch_o | output | CHW | Channel to connect, valid with `connect_o` |
| irq_o | output | NUM_CH | One-cycle completion interrupt, one bit per channel |

## Verification
The assertions check these rules on every cycle:
- the exact SCL phase length;
- the ban on SDA falling while SCL is released;
- the STOP edge being the last bus event and coinciding with connect;
- the count of eleven SCL lows before a recovery connect;
- the one-hot interrupt aimed at the connected channel;
- released lines whenever the block is not busy.

Only the bench scenarios can show the rest:
- the absolute connect latency relative to the start pulse;
- that a second start during a sequence has no effect on timing or channel;
- that a reset at any point of the sequence leaves the bus released with no late connect;
- that the bypass path never touches the lines.

// File: rtl/i2crec_pkg.sv
package i2crec_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_BYPASS,
        ST_CLK_LO,
        ST_CLK_HI,
        ST_NACK_LO,
        ST_NACK_HI,
        ST_STOP_LO,
        ST_STOP_HI,
        ST_FINISH
    } rec_state_e;

    // Output request decoded from the state; registered by the line driver.
    typedef struct packed {
        logic scl_pull;
        logic sda_pull;
        logic busy;
        logic connect;
        logic irq_en;
    } line_req_t;

    localparam line_req_t LINE_REQ_IDLE = '{default: 1'b0};

endpackage

// File: rtl/i2crec_phase_timer.sv
module i2crec_phase_timer #(
    parameter int PHASE_CYC = 500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold,
    output logic phase_first,
    output logic phase_end
);
    localparam int CW = (PHASE_CYC > 1) ? $clog2(PHASE_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(PHASE_CYC - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (hold || cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign phase_first = (cnt_q == '0);
    assign phase_end   = (cnt_q == LAST);

endmodule

// File: rtl/i2crec_pulse_counter.sv
module i2crec_pulse_counter #(
    parameter int NUM_PULSES = 9
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic step,
    output logic last
);
    localparam int PW = $clog2(NUM_PULSES + 1);
    localparam logic [PW-1:0] FINAL = PW'(NUM_PULSES - 1);

    logic [PW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (step) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign last = (cnt_q == FINAL);

endmodule

// File: rtl/i2crec_line_drv.sv
module i2crec_line_drv
    import i2crec_pkg::*;
#(
    parameter int NUM_CH = 2,
    localparam int CHW   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  line_req_t       req,
    input  logic [CHW-1:0]  chan,
    output logic            scl_pull_o,
    output logic            sda_pull_o,
    output logic            busy_o,
    output logic            connect_o,
    output logic [CHW-1:0]  conn_ch_o,
    output logic [NUM_CH-1:0] irq_o
);
    logic [NUM_CH-1:0] irq_d;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_irq
        assign irq_d[g] = req.irq_en && (chan == CHW'(g));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pull_o <= 1'b0;
            sda_pull_o <= 1'b0;
            busy_o     <= 1'b0;
            connect_o  <= 1'b0;
            conn_ch_o  <= '0;
            irq_o      <= '0;
        end else begin
            scl_pull_o <= req.scl_pull;
            sda_pull_o <= req.sda_pull;
            busy_o     <= req.busy;
            connect_o  <= req.connect;
            conn_ch_o  <= chan;
            irq_o      <= irq_d;
        end
    end

endmodule

// File: rtl/i2c_recovery_seq.sv
module i2c_recovery_seq
    import i2crec_pkg::*;
#(
    parameter int PHASE_CYC  = 500,
    parameter int NUM_PULSES = 9,
    parameter int NUM_CH     = 2,
    localparam int CHW       = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              recov_en_i,
    input  logic [CHW-1:0]    req_ch_i,
    output logic              scl_pull_o,
    output logic              sda_pull_o,
    output logic              busy_o,
    output logic              connect_o,
    output logic [CHW-1:0]    conn_ch_o,
    output logic [NUM_CH-1:0] irq_o
);
    rec_state_e     state_q, state_d;
    logic [CHW-1:0] chan_q;
    logic           phase_first, phase_end, pulses_done;
    logic           timer_hold, pulse_clear, pulse_step;
    line_req_t      req;

    initial begin
        if (PHASE_CYC < 2) $error("PHASE_CYC must be at least 2");
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            chan_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && start_i) begin
                chan_q <= req_ch_i;
            end
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (start_i) state_d = recov_en_i ? ST_CLK_LO : ST_BYPASS;
            ST_BYPASS:  state_d = ST_IDLE;
            ST_CLK_LO:  if (phase_end) state_d = ST_CLK_HI;
            ST_CLK_HI:  if (phase_end) state_d = pulses_done ? ST_NACK_LO : ST_CLK_LO;
            ST_NACK_LO: if (phase_end) state_d = ST_NACK_HI;
            ST_NACK_HI: if (phase_end) state_d = ST_STOP_LO;
            ST_STOP_LO: if (phase_end) state_d = ST_STOP_HI;
            ST_STOP_HI: if (phase_end) state_d = ST_FINISH;
            ST_FINISH:  state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // Output decode
    always_comb begin
        req = LINE_REQ_IDLE;
        unique case (state_q)
            ST_IDLE: ;
            ST_BYPASS: begin
                req.busy    = 1'b1;
                req.connect = 1'b1;
            end
            ST_CLK_LO, ST_NACK_LO: begin
                req.busy     = 1'b1;
                req.scl_pull = 1'b1;
            end
            ST_CLK_HI, ST_NACK_HI: begin
                req.busy = 1'b1;
            end
            ST_STOP_LO: begin
                req.busy     = 1'b1;
                req.scl_pull = 1'b1;
                req.sda_pull = !phase_first;
            end
            ST_STOP_HI: begin
                req.busy     = 1'b1;
                req.sda_pull = 1'b1;
            end
            ST_FINISH: begin
                req.busy    = 1'b1;
                req.connect = 1'b1;
                req.irq_en  = 1'b1;
            end
            default: ;
        endcase
    end

    assign timer_hold  = (state_q == ST_IDLE) || (state_q == ST_BYPASS) || (state_q == ST_FINISH);
    assign pulse_clear = (state_q == ST_IDLE);
    assign pulse_step  = (state_q == ST_CLK_HI) && phase_end;

    i2crec_phase_timer #(
        .PHASE_CYC (PHASE_CYC)
    ) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .hold        (timer_hold),
        .phase_first (phase_first),
        .phase_end   (phase_end)
    );

    i2crec_pulse_counter #(
        .NUM_PULSES (NUM_PULSES)
    ) u_pulses (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (pulse_clear),
        .step  (pulse_step),
        .last  (pulses_done)
    );

    i2crec_line_drv #(
        .NUM_CH (NUM_CH)
    ) u_drv (
        .clk        (clk),
        .rst_n      (rst_n),
        .req        (req),
        .chan       (chan_q),
        .scl_pull_o (scl_pull_o),
        .sda_pull_o (sda_pull_o),
        .busy_o     (busy_o),
        .connect_o  (connect_o),
        .conn_ch_o  (conn_ch_o),
        .irq_o      (irq_o)
    );

endmodule

// File: rtl/i2crec_checker.sv
module i2crec_checker #(
    parameter int PHASE_CYC  = 500,
    parameter int NUM_PULSES = 9,
    parameter int NUM_CH     = 2,
    localparam int CHW       = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              scl_pull_o,
    input logic              sda_pull_o,
    input logic              busy_o,
    input logic              connect_o,
    input logic [CHW-1:0]    conn_ch_o,
    input logic [NUM_CH-1:0] irq_o
);
    localparam int RW = $clog2(PHASE_CYC + 1);
    localparam int LW = $clog2(NUM_PULSES + 3);

    logic          scl_prev;
    logic [RW-1:0] run_len;
    logic [LW-1:0] low_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_prev <= 1'b0;
            run_len  <= RW'(PHASE_CYC);
            low_cnt  <= '0;
        end else begin
            scl_prev <= scl_pull_o;
            if (scl_pull_o != scl_prev) begin
                run_len <= RW'(1);
            end else if (run_len < RW'(PHASE_CYC)) begin
                run_len <= run_len + 1'b1;
            end
            if (!busy_o) begin
                low_cnt <= '0;
            end else if (scl_pull_o && !scl_prev) begin
                low_cnt <= low_cnt + 1'b1;
            end
        end
    end

    AST_PHASE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && scl_pull_o != scl_prev) |-> run_len == RW'(PHASE_CYC)); // R4

    AST_LOW_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (connect_o && irq_o != '0) |-> low_cnt == LW'(NUM_PULSES + 2)); // R1

    AST_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pull_o) |-> (scl_pull_o && $past(scl_pull_o))); // R3

    AST_STOP_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sda_pull_o) |-> (!scl_pull_o && connect_o)); // R3

    AST_CONNECT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        connect_o |=> !connect_o); // R5

    AST_IRQ_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(irq_o) && (irq_o == '0 || connect_o)); // R6

    AST_IRQ_CHAN: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o != '0) |-> irq_o[conn_ch_o]); // R6

    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!scl_pull_o && !sda_pull_o && !connect_o)); // R10

endmodule

bind i2c_recovery_seq i2crec_checker #(
    .PHASE_CYC  (PHASE_CYC),
    .NUM_PULSES (NUM_PULSES),
    .NUM_CH     (NUM_CH)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_pull_o (scl_pull_o),
    .sda_pull_o (sda_pull_o),
    .busy_o     (busy_o),
    .connect_o  (connect_o),
    .conn_ch_o  (conn_ch_o),
    .irq_o      (irq_o)
);

// File: tb/i2c_recovery_seq_bench.sv
module i2c_recovery_seq_bench;
    localparam int P      = 3;
    localparam int LAT    = 22 * P + 2;
    localparam int WINDOW = LAT + 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic       recov_en_i = 1'b0;
    logic [0:0] req_ch_i = 1'b0;
    logic       scl_pull_o, sda_pull_o, busy_o, connect_o;
    logic [0:0] conn_ch_o;
    logic [1:0] irq_o;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    i2c_recovery_seq #(
        .PHASE_CYC (P)
    ) u_i2c_recovery_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .recov_en_i (recov_en_i),
        .req_ch_i   (req_ch_i),
        .scl_pull_o (scl_pull_o),
        .sda_pull_o (sda_pull_o),
        .busy_o     (busy_o),
        .connect_o  (connect_o),
        .conn_ch_o  (conn_ch_o),
        .irq_o      (irq_o)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic report;
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // Run one request and watch the bus for a window of cycles.
    task automatic run_seq(input logic ch, input logic en, input bit poke);
        int   conn_at = -1, conn_cnt = 0, lows = 0, sda_rise_idx = -1;
        int   sda_rise_bad = 0, sda_fall_ok = 0, sda_fall_bad = 0, bad_runs = 0;
        int   runlen = 0, busy_mid = 0;
        bit   first_toggle = 1'b1;
        logic prev_scl = 1'b0, prev_sda = 1'b0;
        logic [1:0] irq_cap = '0;
        logic       ch_cap = 1'b0;
        @(negedge clk);
        start_i = 1'b1; recov_en_i = en; req_ch_i = ch;
        for (int n = 1; n <= WINDOW; n++) begin
            @(negedge clk);
            start_i = 1'b0;
            if (poke && n == 10) begin
                start_i = 1'b1; req_ch_i = ~ch;
            end
            if (n == 5) busy_mid = busy_o;
            if (scl_pull_o != prev_scl) begin
                if (!first_toggle && runlen != P) bad_runs++;
                first_toggle = 1'b0;
                runlen = 1;
                if (scl_pull_o) lows++;
            end else begin
                runlen++;
            end
            if (sda_pull_o && !prev_sda) begin
                if (!(scl_pull_o && prev_scl)) sda_rise_bad++;
                if (sda_rise_idx < 0) sda_rise_idx = lows;
            end
            if (!sda_pull_o && prev_sda) begin
                if (!scl_pull_o && connect_o) sda_fall_ok++;
                else sda_fall_bad++;
            end
            if (connect_o) begin
                conn_cnt++; conn_at = n; irq_cap = irq_o; ch_cap = conn_ch_o;
            end
            prev_scl = scl_pull_o; prev_sda = sda_pull_o;
        end
        chk(poke ? "R8" : "R10", "idle after window", int'(busy_o), 0);
        chk(poke ? "R8" : "R6", "connected channel", int'(ch_cap), int'(ch));
        chk(poke ? "R8" : "R5", "connect count", conn_cnt, 1);
        if (en) begin
            chk("R10", "busy mid sequence", busy_mid, 1);
            chk(poke ? "R8" : "R5", "connect latency", conn_at, LAT);
            chk("R1", "SCL low pulses (9 clocks + NACK + STOP)", lows, 11);
            chk("R2", "low index of first SDA pull", sda_rise_idx, 11);
            chk("R3", "SDA pulls while SCL not held low", sda_rise_bad, 0);
            chk("R3", "STOP edges with connect", sda_fall_ok, 1);
            chk("R3", "stray SDA releases", sda_fall_bad, 0);
            chk("R4", "SCL phases of wrong length", bad_runs, 0);
            chk(poke ? "R8" : "R6", "irq vector", int'(irq_cap), 1 << ch);
        end else begin
            chk("R7", "bypass connect latency", conn_at, 2);
            chk("R7", "bypass SCL pulls", lows, 0);
            chk("R7", "bypass SDA pulls", (sda_rise_idx < 0) ? 0 : 1, 0);
            chk("R7", "bypass irq", int'(irq_cap), 0);
        end
    endtask

    // Reset k cycles into a sequence, then make sure nothing follows.
    task automatic abort_at(input int k, input logic ch);
        int late_conn = 0, late_pull = 0;
        @(negedge clk);
        start_i = 1'b1; recov_en_i = 1'b1; req_ch_i = ch;
        @(negedge clk);
        start_i = 1'b0;
        repeat (k - 1) @(negedge clk);
        rst_n = 1'b0;
        #1;
        chk("R9", "lines during reset", int'({scl_pull_o, sda_pull_o, busy_o}), 0);
        @(negedge clk);
        rst_n = 1'b1;
        for (int n = 0; n < WINDOW; n++) begin
            @(negedge clk);
            if (connect_o || irq_o != '0) late_conn++;
            if (scl_pull_o || sda_pull_o || busy_o) late_pull++;
        end
        chk("R9", "late connect after abort", late_conn, 0);
        chk("R9", "bus activity after abort", late_pull, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R10", "reset outputs", int'({scl_pull_o, sda_pull_o, busy_o, connect_o, irq_o}), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R10", "idle outputs", int'({scl_pull_o, sda_pull_o, busy_o, connect_o, irq_o}), 0);
        for (int c = 0; c < 2; c++) begin
            for (int e = 0; e < 2; e++) begin
                run_seq(c[0], e[0], 1'b0);
            end
        end
        run_seq(1'b0, 1'b1, 1'b1);
        run_seq(1'b1, 1'b1, 1'b1);
        run_seq(1'b1, 1'b0, 1'b0);
        run_seq(1'b0, 1'b1, 1'b0);
        for (int k = 1; k <= LAT - 1; k++) begin
            abort_at(k, k[0]);
        end
        run_seq(1'b1, 1'b1, 1'b0);
        report();
    end

endmodule